// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Array for a 32-State Rate-1/2 Trellis

This block is the path-metric engine of a soft-decision trellis decoder for a rate-1/2 convolutional code with 32 states (constraint length 6, generators 65 and 57 octal). The radix-2 trellis is regrouped so that one clock advances the path metrics by two trellis stages. Each state then picks its survivor among four predecessors in one step instead of two chained two-way selections.

Each accepted iteration takes two received symbol pairs, one pair for each of the two collapsed stages, with every symbol on 3 bits. The block forms all sixteen two-stage branch metrics from them. It runs thirty-two four-way add-compare-select cells, grouped as eight radix-4 units of four cells each. It registers the new metrics and a 2-bit survivor decision per state. A trace-back stage downstream stores the decisions, and can also use the metrics to pick a starting state.

Top module: `vit_r4_acs_array`

## Requirements
- R1: After reset the metric of state 0 is 0, every other state metric is 64, `dec_o` is all zero and `valid_o` is low.
- R2: A state is the last five information bits with the newest bit in bit 0. From state s, input bit u forms the window w = {s, u}, which is 6 bits with u in bit 0. The first coded bit is the parity of w AND 65 (octal), the second is the parity of w AND 57 (octal), and the next state is w mod 32. One iteration applies bit u1 and then bit u2, so the next state is {p[2:0], u1, u2}.
- R3: A symbol is an unsigned 3-bit value, where 0 means a confident 0 and 7 means a confident 1. Its distance is r when the expected bit is 0 and 7-r when it is 1. In `sym_s1_i` (first stage) and `sym_s2_i` (second stage), bits [2:0] carry the first coded bit and bits [5:3] carry the second. A candidate's branch metric is the sum of its four distances.
- R4: The new metric of each state is the minimum, over its four predecessors, of the predecessor metric plus the two-stage branch metric, taken modulo 256.
- R5: The decision of state n is the predecessor index k = p[4:3] of the winning predecessor p = {k, n[4:2]}. On a tie the lowest k wins. The decision of state n appears at `dec_o[2n+1:2n]`.
- R6: The metric of state n appears at `metric_o[8n+7:8n]`.
- R7: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. `metric_o` and `dec_o` show that iteration's result in the same cycle, so back-to-back iterations are accepted.
- R8: While `valid_i` is low, `metric_o` and `dec_o` keep their values whatever the symbol inputs do.
- R9: Metrics wrap modulo 256 and are compared by the sign of their 8-bit difference. Arbitrarily long runs therefore give the same minimum and decision as unbounded arithmetic, with no renormalisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Symbol inputs hold one iteration |
| sym_s1_i | input | 6 | Soft symbol pair for the first collapsed stage |
| sym_s2_i | input | 6 | Soft symbol pair for the second collapsed stage |
| valid_o | output | 1 | Metrics and decisions were updated at the last edge |
| metric_o | output | 256 | State metrics, 8 bits per state |
| dec_o | output | 64 | Survivor decisions, 2 bits per state |

## Verification
Every metric feeds four successors at the next iteration. A wrong metric or a wrong branch label therefore shows up in `metric_o` one cycle after the faulty iteration and spreads to every state within three iterations. A wrong tie-break or tournament leg shows up only in `dec_o`, and only in cycles where candidates are equal or close. This is why the bench checks the first iterations after reset, where many states tie at 64. It also runs enough iterations to wrap the 8-bit metrics, because a comparison that ignores the modular sign would go wrong there.

// File: rtl/vit_r4_pkg.sv
package vit_r4_pkg;
  localparam int STATE_BITS_D = 5;
  localparam int SYM_W_D      = 3;
  localparam int PM_W_D       = 8;
  localparam int INIT_PM_D    = 64;
  localparam int GEN_A_D      = 'o65;
  localparam int GEN_B_D      = 'o57;

  // Coded bit pair for an encoder window: bit0 from gen_a, bit1 from gen_b.
  function automatic logic [1:0] enc_pair(input int unsigned w, input int unsigned gen_a,
                                          input int unsigned gen_b);
    return {^(w & gen_b), ^(w & gen_a)};
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
  parameter int SYM_W = 3,
  parameter int BM_W  = SYM_W + 2
) (
  input  logic [2*SYM_W-1:0] sym_s1_i,
  input  logic [2*SYM_W-1:0] sym_s2_i,
  output logic [16*BM_W-1:0] bm_o
);
  localparam int SMAX = (1 << SYM_W) - 1;
  localparam int SM_W = SYM_W + 1;

  logic [SM_W-1:0] sm1 [4];
  logic [SM_W-1:0] sm2 [4];

  function automatic logic [SM_W-1:0] pair_dist(input logic [2*SYM_W-1:0] sym,
                                                input logic [1:0] code);
    logic [SYM_W-1:0] r0, r1, d0, d1;
    r0 = sym[SYM_W-1:0];
    r1 = sym[2*SYM_W-1:SYM_W];
    d0 = code[0] ? SYM_W'(SMAX) - r0 : r0;
    d1 = code[1] ? SYM_W'(SMAX) - r1 : r1;
    return {1'b0, d0} + {1'b0, d1};
  endfunction

  for (genvar e = 0; e < 4; e++) begin : g_stage
    assign sm1[e] = pair_dist(sym_s1_i, 2'(e));
    assign sm2[e] = pair_dist(sym_s2_i, 2'(e));
  end

  // label = {code stage 1, code stage 2}
  for (genvar l = 0; l < 16; l++) begin : g_lbl
    assign bm_o[l*BM_W +: BM_W] = BM_W'(sm1[l >> 2]) + BM_W'(sm2[l & 3]);
  end
endmodule

// File: rtl/vit_acs4.sv
module vit_acs4 #(
  parameter int PM_W = 8,
  parameter int BM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4*PM_W-1:0] pm_i,
  input  logic [4*BM_W-1:0] bm_i,
  output logic [PM_W-1:0]   pm_o,
  output logic [1:0]        dec_o
);
  function automatic logic mod_lt(input logic [PM_W-1:0] a, input logic [PM_W-1:0] b);
    logic [PM_W-1:0] d;
    d = a - b;
    return d[PM_W-1];
  endfunction

  logic [PM_W-1:0] cand [4];
  logic [PM_W-1:0] lo, hi;
  logic            lo_sel, hi_sel, top_sel;

  for (genvar k = 0; k < 4; k++) begin : g_add
    assign cand[k] = pm_i[k*PM_W +: PM_W] + PM_W'(bm_i[k*BM_W +: BM_W]);
  end

  // Strict less-than keeps the lower index on ties at every leg.
  always_comb begin
    lo_sel  = mod_lt(cand[1], cand[0]);
    hi_sel  = mod_lt(cand[3], cand[2]);
    lo      = lo_sel ? cand[1] : cand[0];
    hi      = hi_sel ? cand[3] : cand[2];
    top_sel = mod_lt(hi, lo);
    pm_o    = top_sel ? hi : lo;
    dec_o   = top_sel ? {1'b1, hi_sel} : {1'b0, lo_sel};
  end

  for (genvar k = 0; k < 4; k++) begin : g_min_chk
    // R4
    min_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mod_lt(cand[k], pm_o));
  end

  for (genvar k = 0; k < 3; k++) begin : g_tie_chk
    // R5
    tie_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_o > 2'(k)) |-> mod_lt(pm_o, cand[k]));
  end
endmodule

// File: rtl/vit_r4_unit.sv
module vit_r4_unit
  import vit_r4_pkg::*;
#(
  parameter int STATE_BITS = STATE_BITS_D,
  parameter int PM_W       = PM_W_D,
  parameter int BM_W       = SYM_W_D + 2,
  parameter int GEN_A      = GEN_A_D,
  parameter int GEN_B      = GEN_B_D,
  parameter int GRP        = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4*PM_W-1:0]  pm_i,
  input  logic [16*BM_W-1:0] bm_i,
  output logic [4*PM_W-1:0]  pm_o,
  output logic [7:0]         dec_o
);
  localparam int SMASK  = (1 << STATE_BITS) - 1;
  localparam int GSHIFT = STATE_BITS - 2;

  // Cell j serves state {GRP, j}; candidate k is predecessor {k, GRP}.
  for (genvar j = 0; j < 4; j++) begin : g_cell
    logic [4*BM_W-1:0] bm_sel;
    for (genvar k = 0; k < 4; k++) begin : g_pred
      localparam int P   = (k << GSHIFT) | GRP;
      localparam int W1  = (P << 1) | (j >> 1);
      localparam int W2  = ((W1 & SMASK) << 1) | (j & 1);
      localparam int LBL = int'(enc_pair(W1, GEN_A, GEN_B)) * 4
                         + int'(enc_pair(W2, GEN_A, GEN_B));
      assign bm_sel[k*BM_W +: BM_W] = bm_i[LBL*BM_W +: BM_W];
    end

    vit_acs4 #(.PM_W(PM_W), .BM_W(BM_W)) acs_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pm_i  (pm_i),
      .bm_i  (bm_sel),
      .pm_o  (pm_o[j*PM_W +: PM_W]),
      .dec_o (dec_o[2*j +: 2])
    );
  end
endmodule

// File: rtl/vit_r4_acs_array.sv
module vit_r4_acs_array
  import vit_r4_pkg::*;
#(
  parameter int STATE_BITS = STATE_BITS_D,
  parameter int SYM_W      = SYM_W_D,
  parameter int PM_W       = PM_W_D,
  parameter int INIT_PM    = INIT_PM_D,
  parameter int GEN_A      = GEN_A_D,
  parameter int GEN_B      = GEN_B_D,
  localparam int NS        = 1 << STATE_BITS,
  localparam int NG        = NS / 4,
  localparam int BM_W      = SYM_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2*SYM_W-1:0] sym_s1_i,
  input  logic [2*SYM_W-1:0] sym_s2_i,
  output logic               valid_o,
  output logic [NS*PM_W-1:0] metric_o,
  output logic [2*NS-1:0]    dec_o
);
  logic [NS*PM_W-1:0] pm_q, pm_d;
  logic [2*NS-1:0]    dec_q, dec_d;
  logic               valid_q;
  logic [16*BM_W-1:0] bm;

  vit_bmu #(.SYM_W(SYM_W), .BM_W(BM_W)) bmu_i (
    .sym_s1_i(sym_s1_i),
    .sym_s2_i(sym_s2_i),
    .bm_o    (bm)
  );

  for (genvar g = 0; g < NG; g++) begin : g_unit
    logic [4*PM_W-1:0] pred;
    for (genvar k = 0; k < 4; k++) begin : g_pm
      assign pred[k*PM_W +: PM_W] = pm_q[(k*NG+g)*PM_W +: PM_W];
    end

    vit_r4_unit #(
      .STATE_BITS(STATE_BITS), .PM_W(PM_W), .BM_W(BM_W),
      .GEN_A(GEN_A), .GEN_B(GEN_B), .GRP(g)
    ) unit_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pm_i  (pred),
      .bm_i  (bm),
      .pm_o  (pm_d[4*g*PM_W +: 4*PM_W]),
      .dec_o (dec_d[8*g +: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++)
        pm_q[s*PM_W +: PM_W] <= (s == 0) ? '0 : PM_W'(INIT_PM);
      dec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        pm_q  <= pm_d;
        dec_q <= dec_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign metric_o = pm_q;
  assign dec_o    = dec_q;

  // R7
  lat_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  lat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(metric_o) && $stable(dec_o)));
endmodule

// File: tb/vit_r4_acs_array_tb_top.sv
`timescale 1ns/1ps
module vit_r4_acs_array_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [5:0]   s1 = '0, s2 = '0;
  logic         valid_o;
  logic [255:0] metric_o;
  logic [63:0]  dec_o;

  int n_chk = 0;
  int n_fail = 0;
  longint ref_pm [32];
  int     ref_dec [32];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  vit_r4_acs_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .sym_s1_i(s1), .sym_s2_i(s2),
    .valid_o(valid_o), .metric_o(metric_o), .dec_o(dec_o)
  );

  function automatic int par6(input int w, input int g);
    int p = 0;
    for (int b = 0; b < 6; b++) if (((w >> b) & 1) && ((g >> b) & 1)) p ^= 1;
    return p;
  endfunction

  function automatic int sdist(input int r, input int bit_v);
    return bit_v ? 7 - r : r;
  endfunction

  function automatic int stage_bm(input int w, input logic [5:0] sym);
    return sdist(int'(sym[2:0]), par6(w, 'o65)) + sdist(int'(sym[5:3]), par6(w, 'o57));
  endfunction

  task automatic model_step(input logic [5:0] a, input logic [5:0] b);
    longint nxt [32];
    for (int n = 0; n < 32; n++) begin
      longint best = 64'h7fff_ffff_ffff;
      int kb = 0;
      for (int k = 0; k < 4; k++) begin
        int p = k * 8 + (n >> 2);
        int w1 = (p << 1) | ((n >> 1) & 1);
        int w2 = ((w1 & 31) << 1) | (n & 1);
        longint c = ref_pm[p] + stage_bm(w1, a) + stage_bm(w2, b);
        if (c < best) begin best = c; kb = k; end
      end
      nxt[n] = best;
      ref_dec[n] = kb;
    end
    for (int n = 0; n < 32; n++) ref_pm[n] = nxt[n];
  endtask

  task automatic check_all(input string req);
    int bad_m = -1, bad_d = -1;
    for (int n = 31; n >= 0; n--) begin
      if (int'(metric_o[8*n +: 8]) != int'(ref_pm[n] % 256)) bad_m = n;
      if (int'(dec_o[2*n +: 2]) != ref_dec[n]) bad_d = n;
    end
    n_chk += 2;
    if (bad_m >= 0) begin
      n_fail++;
      $display("FAIL %s metric state %0d: got %0d exp %0d", req, bad_m,
               metric_o[8*bad_m +: 8], ref_pm[bad_m] % 256);
    end
    if (bad_d >= 0) begin
      n_fail++;
      $display("FAIL %s decision state %0d: got %0d exp %0d", req, bad_d,
               dec_o[2*bad_d +: 2], ref_dec[bad_d]);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b exp %0b", req, got, exp);
    end
  endtask

  // One iteration per call; consecutive calls run back to back.
  task automatic iterate(input logic [5:0] a, input logic [5:0] b, input string req);
    s1 = a; s2 = b; valid_i = 1'b1;
    model_step(a, b);
    @(negedge clk);
    check_bit({req, " R7 valid_o"}, valid_o, 1'b1);
    check_all(req);
  endtask

  task automatic idle();
    valid_i = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [5:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[5:0];
  endfunction

  task automatic t_reset();
    for (int n = 0; n < 32; n++) begin
      ref_pm[n] = (n == 0) ? 0 : 64;
      ref_dec[n] = 0;
    end
    rst_n = 1'b0; valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 R6 reset");
    check_bit("R1 valid_o after reset", valid_o, 1'b0);
  endtask

  // All-zero codeword: tie-heavy first iterations, state 0 stays at 0.
  task automatic t_clean_zero();
    for (int i = 0; i < 6; i++) iterate(6'd0, 6'd0, "R2 R3 R4 R5 zero word");
    n_chk++;
    if (metric_o[7:0] != 8'd0) begin
      n_fail++;
      $display("FAIL R4 state0 metric: got %0d exp 0", metric_o[7:0]);
    end
    idle();
  endtask

  // Encoded info sequence with confident symbols: true path keeps metric 0.
  task automatic t_clean_seq();
    int st = 0;
    bit [15:0] info = 16'b1011_0010_1110_0101;
    t_reset();
    for (int i = 0; i < 8; i++) begin
      logic [5:0] sy [2];
      for (int h = 0; h < 2; h++) begin
        int w = (st << 1) | info[2*i+h];
        sy[h] = {par6(w, 'o57) ? 3'd7 : 3'd0, par6(w, 'o65) ? 3'd7 : 3'd0};
        st = w & 31;
      end
      iterate(sy[0], sy[1], "R2 R3 R4 coded seq");
    end
    n_chk++;
    if (metric_o[8*st +: 8] != 8'd0) begin
      n_fail++;
      $display("FAIL R2 end state %0d metric: got %0d exp 0", st, metric_o[8*st +: 8]);
    end
    idle();
  endtask

  task automatic t_noisy();
    for (int i = 0; i < 40; i++) iterate(next_rand(), next_rand(), "R4 R5 noisy");
    idle();
  endtask

  task automatic t_hold();
    logic [255:0] m0;
    logic [63:0]  d0;
    m0 = metric_o; d0 = dec_o;
    valid_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      s1 = next_rand(); s2 = next_rand();
      @(negedge clk);
      check_bit("R8 R7 valid_o low", valid_o, 1'b0);
    end
    n_chk++;
    if (metric_o !== m0 || dec_o !== d0) begin
      n_fail++;
      $display("FAIL R8 hold: got %h exp %h", metric_o[63:0], m0[63:0]);
    end
    check_all("R8 hold model");
  endtask

  task automatic t_latency();
    iterate(6'o17, 6'o61, "R7 single pulse");
    idle();
    check_bit("R7 valid_o drops", valid_o, 1'b0);
  endtask

  // Anti-codeword symbols push metrics far beyond 255.
  task automatic t_wrap();
    for (int i = 0; i < 300; i++)
      iterate((i % 3 == 0) ? 6'o77 : next_rand(), 6'o70, "R9 wrap");
    n_chk++;
    if (ref_pm[0] < 256) begin
      n_fail++;
      $display("FAIL R9 wrap not reached: got %0d exp >=256", ref_pm[0]);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clean_zero();
    t_clean_seq();
    t_noisy();
    t_hold();
    t_latency();
    t_wrap();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule